// File: doc/BRIEF.md
# Periodic Tick Interrupt Timer

This block raises a periodic interrupt request from a single free-running oscillator clock. A 7-bit rate register sets the period. Its upper three bits are an exponent for a binary prescaler, and its lower four bits are a modulus that counts prescaler wraps. When both counters reach their terminal values, a sticky time-out flag is set. The interrupt request is driven from that flag, gated by an enable bit.

Software reaches three byte-wide registers through a single-cycle write/read port clocked by the same oscillator clock:

| Address | Register | Content |
|---------|----------|---------|
| 0 | rate | prescale exponent and modulus |
| 1 | enable | enable bit |
| 2 | flag | time-out flag |

The flag is cleared by writing a one to it. A zero exponent parks the timer. Any write to the rate register restarts the period from zero, so the first interrupt after a reconfiguration always arrives a full period later.

The period is (modulus + 1) × 2^(exponent + BASE_SHIFT) clock cycles. With the default BASE_SHIFT of 9, an exponent of 1 gives a 1024-cycle prescale step.

Top module: `rti_timer`

## Requirements
- R1: After reset, every register reads 0 and `irq` is 0. The interrupt is therefore disabled coming out of reset.
- R2: The flag becomes 1 exactly (m+1)·2^(p+BASE_SHIFT) clock edges after a rate write, and not one edge earlier. Here p is rate bits [6:4] (1..7) and m is rate bits [3:0].
- R3: While p is nonzero, time-outs repeat with the same period for as long as the configuration is unchanged.
- R4: A prescale exponent p of 0 stops the timer, holds both counters at zero, and never sets the flag.
- R5: Every write to the rate register, even one with an unchanged value, restarts both counters, so the next time-out comes one full period after that write.
- R6: Writing the flag register (address 2) with bit 7 set clears the flag. Bits 6:0 of that write and a write with bit 7 at 0 leave the flag unchanged.
- R7: `irq` is 1 exactly when the enable bit and the flag are both 1.
- R8: When a time-out and a flag clear occur at the same clock edge, the flag ends at 1.
- R9: `rdData` is combinational from `addr`:
  - address 0 returns {0, rate[6:0]}
  - address 1 returns {enable, 7'b0}
  - address 2 returns {flag, 7'b0}
  - address 3 returns 0
- R10: A write to address 1 stores bit 7 of `wrData` as the enable bit. All other bits are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Oscillator clock; timer and registers run on it |
| rstN | input | 1 | Asynchronous reset, active low |
| wrEn | input | 1 | Register write strobe |
| addr | input | 2 | Register address (0 rate, 1 enable, 2 flag) |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for `addr` |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with BASE_SHIFT set to 0, so a prescale step lasts 2^p cycles instead of 2^(p+9). At that setting the full exponent range, 1 through 7, and modulus values up to 15 produce periods of 2 to 2048 cycles. Every period can then be checked edge by edge. The two-cycle minimum period at p=1, m=0 also lets a write-one clear land on the very edge of a time-out, which exercises the set-over-clear priority.

// File: rtl/rti_pkg.sv
package rti_pkg;
  localparam int RATE_W = 7;
  localparam int PSEL_W = 3;
  localparam int MSEL_W = 4;
  localparam int DATA_W = 8;
  localparam int ADDR_W = 2;

  localparam logic [ADDR_W-1:0] ADDR_RATE = 2'd0;
  localparam logic [ADDR_W-1:0] ADDR_ENA  = 2'd1;
  localparam logic [ADDR_W-1:0] ADDR_FLAG = 2'd2;

  typedef struct packed {
    logic              restart;
    logic              run;
    logic [PSEL_W-1:0] preSel;
    logic [MSEL_W-1:0] modSel;
  } rtiStrobe_t;
endpackage

// File: rtl/rti_datapath.sv
module rti_datapath
  import rti_pkg::*;
#(
  parameter int BASE_SHIFT = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  rtiStrobe_t strb,
  output logic       tmo
);
  localparam int MAX_P = (1 << PSEL_W) - 1;
  localparam int PRE_W = MAX_P + BASE_SHIFT;

  logic [PRE_W-1:0]  preCnt;
  logic [PRE_W-1:0]  limMask;
  logic [MSEL_W-1:0] modCnt;
  logic              preWrap;

  // Terminal count of the prescaler: the low (p + BASE_SHIFT) bits set
  for (genvar g = 0; g < PRE_W; g++) begin : g_mask
    assign limMask[g] = (g < (int'(strb.preSel) + BASE_SHIFT));
  end

  assign preWrap = strb.run && (preCnt == limMask);
  assign tmo     = preWrap && (modCnt == strb.modSel);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      modCnt <= '0;
    end else if (strb.restart || !strb.run) begin
      preCnt <= '0;
      modCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
      modCnt <= (modCnt == strb.modSel) ? '0 : modCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end
endmodule

// File: rtl/rti_ctrl.sv
module rti_ctrl
  import rti_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              tmo,
  output rtiStrobe_t        strb,
  output logic [RATE_W-1:0] rateReg,
  output logic              enable,
  output logic              flag
);
  logic wrRate, wrEna, wrFlag;

  assign wrRate = wrEn && (addr == ADDR_RATE);
  assign wrEna  = wrEn && (addr == ADDR_ENA);
  assign wrFlag = wrEn && (addr == ADDR_FLAG);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rateReg <= '0;
      enable  <= 1'b0;
      flag    <= 1'b0;
    end else begin
      if (wrRate) rateReg <= wrData[RATE_W-1:0];
      if (wrEna)  enable  <= wrData[DATA_W-1];
      if (tmo)    flag    <= 1'b1;
      else if (wrFlag && wrData[DATA_W-1]) flag <= 1'b0;
    end
  end

  assign strb.restart = wrRate;
  assign strb.preSel  = rateReg[RATE_W-1 -: PSEL_W];
  assign strb.modSel  = rateReg[MSEL_W-1:0];
  assign strb.run     = (strb.preSel != '0);
endmodule

// File: rtl/rti_timer.sv
module rti_timer
  import rti_pkg::*;
#(
  parameter int BASE_SHIFT = 9
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       wrEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic       irq
);
  rtiStrobe_t        strb;
  logic              tmo;
  logic              enable;
  logic              flag;
  logic [RATE_W-1:0] rateReg;

  rti_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
    .tmo(tmo), .strb(strb), .rateReg(rateReg), .enable(enable), .flag(flag)
  );

  rti_datapath #(.BASE_SHIFT(BASE_SHIFT)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .tmo(tmo)
  );

  assign irq = enable & flag;

  always_comb begin
    case (addr)
      ADDR_RATE: rdData = {1'b0, rateReg};
      ADDR_ENA:  rdData = {enable, 7'b0};
      ADDR_FLAG: rdData = {flag, 7'b0};
      default:   rdData = '0;
    endcase
  end
endmodule

// File: rtl/rti_timer_chk.sv
module rti_timer_chk (
  input logic       clk,
  input logic       rstN,
  input logic       wrEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic [2:0] preSel,
  input logic       tmo,
  input logic       enable,
  input logic       flag,
  input logic       irq
);
  logic clrReq;
  assign clrReq = wrEn && (addr == 2'd2) && wrData[7];

  p_stop_r4: assert property (@(posedge clk) disable iff (!rstN)
    (preSel == 3'd0) |-> !tmo);

  p_restart_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && addr == 2'd0) |=> !tmo);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    (clrReq && !tmo) |=> !flag);

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    (flag && !clrReq) |=> flag);

  p_irq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (enable && tmo && !(wrEn && addr == 2'd1)) |=> irq);

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    (tmo && clrReq) |=> flag);
endmodule

bind rti_timer rti_timer_chk u_chk (
  .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr), .wrData(wrData),
  .preSel(strb.preSel), .tmo(tmo), .enable(enable), .flag(flag), .irq(irq)
);

// File: tb/rti_timer_bench.sv
module rti_timer_bench;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       wrEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'd0;
  logic [7:0] rdData;
  logic       irq;

  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #4 clk = ~clk;

  rti_timer #(.BASE_SHIFT(0)) u_rti_timer (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  // {p, m} pairs; period = (m+1) << p with BASE_SHIFT 0
  localparam logic [6:0] VEC [6] = '{7'h10, 7'h13, 7'h20, 7'h35, 7'h70, 7'h4F};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wrReg(input logic [1:0] a, input logic [7:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(posedge clk);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rdReg(input logic [1:0] a, output logic [7:0] d);
    addr = a;
    #1;
    d = rdData;
  endtask

  task automatic waitN(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin
    logic [7:0] v;
    int n;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    for (int a = 0; a < 4; a++) begin
      rdReg(2'(a), v);
      check("R1 reg", v, 8'h00);
    end
    check("R1 irq", {7'b0, irq}, 8'h00);

    // R9 / R10 readback
    wrReg(2'd0, 8'hDA);
    rdReg(2'd0, v); check("R9 rate readback", v, 8'h5A);
    wrReg(2'd1, 8'h7F);
    rdReg(2'd1, v); check("R10 enable bit7 only", v, 8'h00);
    wrReg(2'd1, 8'hFF);
    rdReg(2'd1, v); check("R10 enable set", v, 8'h80);
    rdReg(2'd3, v); check("R9 addr3 zero", v, 8'h00);

    // R2 / R3 table walk
    for (int k = 0; k < 6; k++) begin
      n = (int'(VEC[k][3:0]) + 1) << VEC[k][6:4];
      wrReg(2'd0, {1'b0, VEC[k]});        // restart at edge e
      wrReg(2'd2, 8'h80);                 // clear at e+1
      waitN(n - 2);
      rdReg(2'd2, v); check("R2 no early flag", v, 8'h00);
      waitN(1);
      rdReg(2'd2, v); check("R2 flag at period", v, 8'h80);
      check("R7 irq with enable", {7'b0, irq}, 8'h01);
      wrReg(2'd2, 8'h80);                 // clear at e+n+1
      waitN(n - 2);
      rdReg(2'd2, v); check("R3 no early repeat", v, 8'h00);
      waitN(1);
      rdReg(2'd2, v); check("R3 repeat period", v, 8'h80);
    end

    // R6 write-one-to-clear semantics (flag is 1, stop timer first)
    wrReg(2'd0, 8'h00);
    wrReg(2'd2, 8'h7F);
    rdReg(2'd2, v); check("R6 zero bit7 ignored", v, 8'h80);
    // R7 enable off masks irq
    wrReg(2'd1, 8'h00);
    check("R7 irq masked", {7'b0, irq}, 8'h00);
    wrReg(2'd1, 8'h80);
    check("R7 irq back", {7'b0, irq}, 8'h01);
    wrReg(2'd2, 8'h80);
    rdReg(2'd2, v); check("R6 clear", v, 8'h00);
    check("R7 irq after clear", {7'b0, irq}, 8'h00);

    // R4 stopped timer
    wrReg(2'd0, 8'h0F);
    waitN(3000);
    rdReg(2'd2, v); check("R4 stopped", v, 8'h00);

    // R5 restart: period 4, rewrite after 2 edges
    wrReg(2'd0, 8'h20);
    wrReg(2'd2, 8'h80);
    wrReg(2'd0, 8'h20);                   // restart at e+2
    waitN(2);                             // original e+4 = new+2
    rdReg(2'd2, v); check("R5 restart delays", v, 8'h00);
    waitN(1);                             // new+3
    rdReg(2'd2, v); check("R5 still early", v, 8'h00);
    waitN(1);                             // new+4
    rdReg(2'd2, v); check("R5 fires after restart", v, 8'h80);

    // R8 set wins over clear at the same edge (period 2)
    wrReg(2'd0, 8'h10);                   // edge e
    wrReg(2'd2, 8'h80);                   // e+1, clear
    wrReg(2'd2, 8'h80);                   // e+2, coincides with time-out
    rdReg(2'd2, v); check("R8 set wins", v, 8'h80);

    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 150000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=hung expected=done");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule